// File: doc/BRIEF.md
# Multiplexed-Bus Burst ROM Reader

This block is the host side of a slow external ROM reached through one shared 16-bit address/data bus. A transfer is requested with a single-cycle start pulse carrying a 22-bit word address, a 4-bit device code, an active-low enable and a word count. The block then runs a two-step address cycle on two address strobes, waits out the first-access latency, and issues a train of read strobes. It captures one 16-bit word per strobe and hands each word to the user with a one-cycle valid flag.

The ROM steps its own address on every read strobe, but only within a 256-word page. Because of this, one address cycle can serve a whole run of words that stays inside a page. When a transfer reaches the start of a new page, the block releases the strobes and runs a fresh address cycle before it continues. Every delay is written as a time in nanoseconds and is turned into a cycle count by rounding up against the clock-period parameter. The smallest count is one cycle.

Top module: `mrom_burst_reader`

## Requirements
- R1: After reset and while idle, both address strobes and the read strobe are high, the bus is not driven (`bus_oe` low), `rom_sel_n`, `done` and `rd_valid` are at their inactive levels, and `rom_sel_n` is high.
- R2: In the first address step, `addr_stb_hi` falls while `addr_stb_lo` is high. At that edge the bus carries address bits [21:15] on bits [6:0], device-code bits [3:2] on bits [12:11] and code bits [1:0] on bits [8:7]. At the same edge `rom_sel_n` equals the `enable_n` value taken with the start pulse.
- R3: In the second address step, `addr_stb_lo` falls while `addr_stb_hi` is low. At that edge the bus carries address bits [14:0] on bits [15:1], and bit 0 is zero.
- R4: The bus value is held for at least ceil(T_ADDR_SETUP_NS/CLK_PERIOD_NS) cycles before each address-strobe fall. `addr_stb_lo` is high for at least ceil(T_STB_GUARD_NS/CLK_PERIOD_NS) cycles before the fall of `addr_stb_hi`, and stays high for at least that many cycles after it.
- R5: The first read-strobe fall after an address cycle comes at least ceil(T_FIRST_NS/CLK_PERIOD_NS) cycles after `addr_stb_lo` falls. `bus_oe` goes low at that `addr_stb_lo` fall and stays low while `read_stb_n` is low.
- R6: Successive read-strobe falls are at least ceil(T_RD_PERIOD_NS/CLK_PERIOD_NS) cycles apart. The strobe stays high for at least ceil(T_RD_HIGH_NS/CLK_PERIOD_NS) cycles. The bus is sampled at least ceil(T_RD_DATA_NS/CLK_PERIOD_NS) cycles after the fall, in the cycle before the strobe rises. `rd_valid` is high for exactly the last low cycle of each strobe.
- R7: A transfer delivers exactly `word_count` words, taken from ascending word addresses that start at `word_address`, with one read strobe per word.
- R8: When the next word address has bits [7:0] equal to zero and words remain, all three strobes return high and a new address cycle is run for that address. The 22-bit address wraps from 3FFFFF to 0.
- R9: After the last word, `done` is high for exactly one cycle. During that cycle all strobes are high and `bus_oe` is low.
- R10: A start with `word_count` zero raises `done` in the next cycle and produces no strobe activity.
- R11: A start pulse that arrives while a transfer is running is ignored. It does not change the running word stream, and no further transfer follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle transfer request, taken only when idle |
| word_addr | input | 22 | First word address |
| dev_code | input | 4 | Device code sent during the first address step |
| enable_n | input | 1 | Active-low enable forwarded to `rom_sel_n` |
| word_count | input | CNT_W | Number of words to read |
| bus_in | input | 16 | Bus value seen at the pads |
| bus_out | output | 16 | Value driven onto the bus when `bus_oe` is high |
| bus_oe | output | 1 | Bus drive enable |
| addr_stb_hi | output | 1 | Upper-address strobe, latches on its falling edge |
| addr_stb_lo | output | 1 | Lower-address strobe, latches on its falling edge |
| read_stb_n | output | 1 | Active-low read strobe |
| rom_sel_n | output | 1 | Active-low chip enable to the ROM |
| rd_data | output | 16 | Captured word |
| rd_valid | output | 1 | `rd_data` holds a new word |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench uses a 20 ns clock period and keeps the default nanosecond figures, with one exception: the read-data delay is raised to 500 ns. With that change, the data-valid wait (26 low cycles) sets the strobe low phase rather than the period rule. A sample taken even one cycle early then reads the placeholder value that the ROM model drives first. The default 2000 ns latency becomes a 100-cycle wait, which keeps page-crossing transfers short. These include the run from 3FFFFE that wraps to address zero, which exercises the page restart and the 22-bit wrap within a few thousand cycles.

// File: rtl/mrb_pkg.sv
`timescale 1ns/1ps
// Shared constants, state type and compile-time helpers for the burst ROM reader.
// Assumes the bus split is fixed: 7 upper bits, 15 lower bits, 8-bit page.
package mrb_pkg;
    localparam int ADDR_W = 22;
    localparam int HI_W   = 7;
    localparam int LO_W   = 15;
    localparam int BUS_W  = 16;
    localparam int CODE_W = 4;
    localparam int PAGE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HSET,
        ST_HHOLD,
        ST_LSET,
        ST_LAT,
        ST_RDL,
        ST_RDH
    } mrb_state_t;

    // Round a time up to whole clock cycles, never below one.
    function automatic int unsigned mrb_cycles(input int unsigned ns, input int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned mrb_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/mrb_timer.sv
`timescale 1ns/1ps
// Phase timer: loaded with (cycles-1) on entry to a phase, counts down to zero.
// Assumes the caller leaves the phase in the cycle where zero is high.
module mrb_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero,
    output logic         one
);
    logic [W-1:0] cnt;

    // Load on phase entry, otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);
    assign one  = (cnt == W'(1));
endmodule

// File: rtl/mrb_track.sv
`timescale 1ns/1ps
// Transfer tracker: holds the current word address, words left, device code
// and enable. Assumes step is high for one cycle per captured word.
module mrb_track
    import mrb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              en_n_i,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CODE_W-1:0] code_q,
    output logic              en_n_q,
    output logic              last,
    output logic              page_top
);
    logic [CNT_W-1:0] left;

    // Take the request on load; advance address and count by one per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            left     <= '0;
            code_q   <= '0;
            en_n_q   <= 1'b1;
        end else if (load) begin
            cur_addr <= addr_i;
            left     <= count_i;
            code_q   <= code_i;
            en_n_q   <= en_n_i;
        end else if (step) begin
            cur_addr <= cur_addr + ADDR_W'(1);
            left     <= left - CNT_W'(1);
        end
    end

    assign last     = (left == '0);
    assign page_top = (cur_addr[PAGE_W-1:0] == '0);
endmodule

// File: rtl/mrom_burst_reader.sv
`timescale 1ns/1ps
// Burst reader for a ROM on a shared 16-bit address/data bus.
// Runs a two-step address cycle, waits the first-access latency, then reads
// one word per read strobe, restarting the address cycle at each 256-word page.
// Assumes the clock period parameter matches the real clock; all strobes are
// decoded from the state register.
module mrom_burst_reader
    import mrb_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS   = 20,
    parameter int unsigned T_ADDR_SETUP_NS = 40,
    parameter int unsigned T_STB_GUARD_NS  = 70,
    parameter int unsigned T_FIRST_NS      = 2000,
    parameter int unsigned T_RD_PERIOD_NS  = 400,
    parameter int unsigned T_RD_HIGH_NS    = 20,
    parameter int unsigned T_RD_DATA_NS    = 150,
    parameter int          CNT_W           = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [21:0]       word_addr,
    input  logic [3:0]        dev_code,
    input  logic              enable_n,
    input  logic [CNT_W-1:0]  word_count,
    input  logic [15:0]       bus_in,
    output logic [15:0]       bus_out,
    output logic              bus_oe,
    output logic              addr_stb_hi,
    output logic              addr_stb_lo,
    output logic              read_stb_n,
    output logic              rom_sel_n,
    output logic [15:0]       rd_data,
    output logic              rd_valid,
    output logic              done
);
    localparam int unsigned N_AS   = mrb_cycles(T_ADDR_SETUP_NS, CLK_PERIOD_NS);
    localparam int unsigned N_GRD  = mrb_cycles(T_STB_GUARD_NS, CLK_PERIOD_NS);
    localparam int unsigned N_LAT  = mrb_cycles(T_FIRST_NS, CLK_PERIOD_NS);
    localparam int unsigned N_PER  = mrb_cycles(T_RD_PERIOD_NS, CLK_PERIOD_NS);
    localparam int unsigned N_HIGH = mrb_cycles(T_RD_HIGH_NS, CLK_PERIOD_NS);
    localparam int unsigned N_DATA = mrb_cycles(T_RD_DATA_NS, CLK_PERIOD_NS);
    localparam int unsigned N_HSET = mrb_max(N_AS, N_GRD);
    localparam int unsigned N_LOW  = mrb_max(N_DATA + 1, (N_PER > N_HIGH) ? N_PER - N_HIGH : 1);
    localparam int unsigned N_MAX  = mrb_max(mrb_max(N_HSET, N_LAT), mrb_max(N_LOW, N_HIGH));
    localparam int          TMR_W  = $clog2(N_MAX + 1);

    localparam logic [TMR_W-1:0] L_HSET = TMR_W'(N_HSET - 1);
    localparam logic [TMR_W-1:0] L_GRD  = TMR_W'(N_GRD - 1);
    localparam logic [TMR_W-1:0] L_AS   = TMR_W'(N_AS - 1);
    localparam logic [TMR_W-1:0] L_LAT  = TMR_W'(N_LAT - 1);
    localparam logic [TMR_W-1:0] L_LOW  = TMR_W'(N_LOW - 1);
    localparam logic [TMR_W-1:0] L_HIGH = TMR_W'(N_HIGH - 1);

    mrb_state_t        st, st_d;
    logic              tmr_load, tmr_zero, tmr_one;
    logic [TMR_W-1:0]  tmr_val;
    logic              trk_load, capture, last, page_top, en_n_q, done_d;
    logic [ADDR_W-1:0] cur_addr;
    logic [CODE_W-1:0] code_q;

    mrb_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero),
        .one      (tmr_one)
    );

    mrb_track #(.CNT_W(CNT_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (trk_load),
        .addr_i   (word_addr),
        .count_i  (word_count),
        .code_i   (dev_code),
        .en_n_i   (enable_n),
        .step     (capture),
        .cur_addr (cur_addr),
        .code_q   (code_q),
        .en_n_q   (en_n_q),
        .last     (last),
        .page_top (page_top)
    );

    // Phase sequencing: each phase lasts the cycles its timer was loaded with.
    always_comb begin
        st_d     = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        trk_load = 1'b0;
        done_d   = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start) begin
                    if (word_count == '0) begin
                        done_d = 1'b1;
                    end else begin
                        st_d     = ST_HSET;
                        trk_load = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = L_HSET;
                    end
                end
            end
            ST_HSET: if (tmr_zero) begin
                st_d = ST_HHOLD; tmr_load = 1'b1; tmr_val = L_GRD;
            end
            ST_HHOLD: if (tmr_zero) begin
                st_d = ST_LSET; tmr_load = 1'b1; tmr_val = L_AS;
            end
            ST_LSET: if (tmr_zero) begin
                st_d = ST_LAT; tmr_load = 1'b1; tmr_val = L_LAT;
            end
            ST_LAT: if (tmr_zero) begin
                st_d = ST_RDL; tmr_load = 1'b1; tmr_val = L_LOW;
            end
            ST_RDL: if (tmr_zero) begin
                st_d = ST_RDH; tmr_load = 1'b1; tmr_val = L_HIGH;
            end
            ST_RDH: if (tmr_zero) begin
                if (last) begin
                    st_d   = ST_IDLE;
                    done_d = 1'b1;
                end else if (page_top) begin
                    st_d = ST_HSET; tmr_load = 1'b1; tmr_val = L_HSET;
                end else begin
                    st_d = ST_RDL; tmr_load = 1'b1; tmr_val = L_LOW;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Sample the bus in the cycle before the read strobe rises.
    assign capture = (st == ST_RDL) && tmr_one;

    // State, done pulse and captured word registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            done     <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            st       <= st_d;
            done     <= done_d;
            rd_valid <= capture;
            if (capture)
                rd_data <= bus_in;
        end
    end

    // Bus word for each address step; zero when not driving.
    always_comb begin
        bus_out = '0;
        unique case (st)
            ST_HSET, ST_HHOLD: begin
                bus_out[HI_W-1:0] = cur_addr[ADDR_W-1:LO_W];
                bus_out[12:11]    = code_q[3:2];
                bus_out[8:7]      = code_q[1:0];
            end
            ST_LSET: bus_out = {cur_addr[LO_W-1:0], 1'b0};
            default: bus_out = '0;
        endcase
    end

    assign bus_oe      = (st == ST_HSET) || (st == ST_HHOLD) || (st == ST_LSET);
    assign addr_stb_hi = (st == ST_IDLE) || (st == ST_HSET);
    assign addr_stb_lo = (st == ST_IDLE) || (st == ST_HSET) || (st == ST_HHOLD) || (st == ST_LSET);
    assign read_stb_n  = (st != ST_RDL);
    assign rom_sel_n   = (st == ST_IDLE) ? 1'b1 : en_n_q;
endmodule

// File: rtl/mrb_checker.sv
`timescale 1ns/1ps
// Protocol checker for the burst reader, attached by bind; observes ports only.
module mrb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] bus_out,
    input logic        bus_oe,
    input logic        addr_stb_hi,
    input logic        addr_stb_lo,
    input logic        read_stb_n,
    input logic        rd_valid,
    input logic        done
);
    // R2: lower strobe high and bus driven when the upper strobe falls
    a_r2_lo_high_at_hi_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_stb_hi) |-> addr_stb_lo && bus_oe);

    // R3: upper strobe low, bus was driven with bit 0 clear, when lower strobe falls
    a_r3_lo_fall_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_stb_lo) |-> !addr_stb_hi && $past(bus_oe) && !$past(bus_out[0]));

    // R5: bus released and both address strobes low during a read strobe
    a_r5_bus_free_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        !read_stb_n |-> !bus_oe && !addr_stb_hi && !addr_stb_lo);

    // R6: valid marks the last low cycle of a strobe
    a_r6_valid_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !read_stb_n);
    a_r6_rise_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> read_stb_n);

    // R8: address strobes return high together
    a_r8_strobes_rise_together: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_stb_lo) |-> addr_stb_hi);

    // R9: single-cycle done with the bus quiet
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> addr_stb_hi && addr_stb_lo && read_stb_n && !bus_oe);
endmodule

bind mrom_burst_reader mrb_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_out     (bus_out),
    .bus_oe      (bus_oe),
    .addr_stb_hi (addr_stb_hi),
    .addr_stb_lo (addr_stb_lo),
    .read_stb_n  (read_stb_n),
    .rd_valid    (rd_valid),
    .done        (done)
);

// File: tb/mrom_burst_reader_tb.sv
`timescale 1ns/1ps
// Scoreboard bench with a cycle-sampled ROM model and timing monitor.
module mrom_burst_reader_tb;
    localparam int CLK_NS  = 20;
    localparam int DATA_NS = 500;
    localparam logic [3:0] DEV = 4'hA;
    localparam int B_AS   = (40 + CLK_NS - 1) / CLK_NS;
    localparam int B_GRD  = (70 + CLK_NS - 1) / CLK_NS;
    localparam int B_LAT  = (2000 + CLK_NS - 1) / CLK_NS;
    localparam int B_PER  = (400 + CLK_NS - 1) / CLK_NS;
    localparam int B_HIGH = (20 + CLK_NS - 1) / CLK_NS;
    localparam int B_DATA = (DATA_NS + CLK_NS - 1) / CLK_NS;

    logic clk = 0, rst_n = 0, start = 0, enable_n = 0;
    logic [21:0] word_addr = '0;
    logic [3:0]  dev_code = '0;
    logic [15:0] word_count = '0;
    logic [15:0] bus_in;
    logic [15:0] bus_out, rd_data;
    logic bus_oe, addr_stb_hi, addr_stb_lo, read_stb_n, rom_sel_n, rd_valid, done;

    int n_run = 0, n_fail = 0;
    logic [15:0] exp_q[$];
    logic [21:0] exp_ptr;
    logic [3:0]  cur_code;
    logic        cur_en_n;
    int hi_falls = 0, strobes = 0;

    // ROM model state
    logic [6:0]  m_hi;
    logic [14:0] m_lo;
    logic [3:0]  m_code;
    logic        m_ce_n = 1'b1;

    always #(CLK_NS/2) clk = ~clk;

    mrom_burst_reader #(.T_RD_DATA_NS(DATA_NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .word_addr(word_addr),
        .dev_code(dev_code), .enable_n(enable_n), .word_count(word_count),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .addr_stb_hi(addr_stb_hi), .addr_stb_lo(addr_stb_lo),
        .read_stb_n(read_stb_n), .rom_sel_n(rom_sel_n),
        .rd_data(rd_data), .rd_valid(rd_valid), .done(done)
    );

    function automatic logic [15:0] romw(input logic [21:0] a);
        return a[15:0] ^ {a[21:16], 10'h155};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ROM data path: placeholder first, word just inside the data delay, pull-up when released.
    initial begin
        bus_in = 16'hFFFF;
        forever begin
            @(negedge read_stb_n);
            if (!m_ce_n && m_code == DEV) begin
                bus_in = 16'h5A5A;
                #(DATA_NS - 1);
                if (!read_stb_n) bus_in = romw({m_hi, m_lo});
            end
            @(posedge read_stb_n);
            bus_in = 16'hFFFF;
        end
    end

    // Cycle monitor: edge detection on samples, ROM latching, timing and scoreboard.
    logic p_hi = 1, p_lo = 1, p_rd = 1, p_valid = 0, p_ce = 1, first_rd = 0;
    logic [15:0] p_ad = '0;
    int ad_same = 0, lo_run = 0, since_hi = 0, since_lo = 0, since_rd = 0, rd_hi_run = 0, rd_lo_run = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_hi && !addr_stb_hi) begin
                hi_falls++;
                check(ad_same >= B_AS, "R4 setup before upper strobe", ad_same, B_AS);
                check(lo_run >= B_GRD, "R4 lower high before upper fall", lo_run, B_GRD);
                check(addr_stb_lo, "R2 lower strobe high", addr_stb_lo, 1);
                check(p_ad[6:0] == exp_ptr[21:15], "R2 upper address", p_ad[6:0], exp_ptr[21:15]);
                check({p_ad[12:11], p_ad[8:7]} == cur_code, "R2 device code", {p_ad[12:11], p_ad[8:7]}, cur_code);
                check(p_ce == cur_en_n, "R2 chip enable", p_ce, cur_en_n);
                m_hi = p_ad[6:0]; m_code = {p_ad[12:11], p_ad[8:7]}; m_ce_n = p_ce;
                since_hi = 0;
            end
            if (p_lo && !addr_stb_lo) begin
                check(since_hi >= B_GRD, "R4 lower high after upper fall", since_hi, B_GRD);
                check(ad_same >= B_AS, "R4 setup before lower strobe", ad_same, B_AS);
                check(!addr_stb_hi, "R3 upper strobe low", addr_stb_hi, 0);
                check({p_ad[15:1], p_ad[0]} == {exp_ptr[14:0], 1'b0}, "R3 lower address", p_ad, {exp_ptr[14:0], 1'b0});
                check(!bus_oe, "R5 bus released at lower fall", bus_oe, 0);
                m_lo = p_ad[15:1];
                since_lo = 0; first_rd = 1;
            end
            if (p_rd && !read_stb_n) begin
                strobes++;
                if (first_rd) check(since_lo >= B_LAT, "R5 first access latency", since_lo, B_LAT);
                else          check(since_rd >= B_PER, "R6 strobe period", since_rd, B_PER);
                check(rd_hi_run >= B_HIGH, "R6 strobe high width", rd_hi_run, B_HIGH);
                check(!bus_oe, "R5 bus released in read", bus_oe, 0);
                first_rd = 0; since_rd = 0;
            end
            if (!p_rd && read_stb_n) m_lo[7:0] = m_lo[7:0] + 8'd1;
            if (rd_valid) begin
                check(!read_stb_n, "R6 valid while strobe low", read_stb_n, 0);
                check(rd_lo_run >= B_DATA, "R6 data delay", rd_lo_run, B_DATA);
                if (exp_q.size() == 0) check(0, "R7 unexpected word", rd_data, 0);
                else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(rd_data == e, "R7 word value", rd_data, e);
                end
                exp_ptr = exp_ptr + 22'd1;
            end
            if (p_valid) check(read_stb_n, "R6 strobe rises after valid", read_stb_n, 1);
        end
        ad_same   = (bus_out == p_ad) ? ad_same + 1 : 1;
        lo_run    = addr_stb_lo ? lo_run + 1 : 0;
        rd_hi_run = read_stb_n ? rd_hi_run + 1 : 0;
        rd_lo_run = read_stb_n ? 0 : rd_lo_run + 1;
        since_hi++; since_lo++; since_rd++;
        p_hi = addr_stb_hi; p_lo = addr_stb_lo; p_rd = read_stb_n;
        p_ad = bus_out; p_ce = rom_sel_n; p_valid = rd_valid;
    end

    // Driver: queue expected words, issue the request, then check the end of transfer.
    task automatic run_xfer(input logic [21:0] a, input int n, input logic [3:0] code,
                            input logic en_n, input bit disturb);
        int pages, h0, s0, waited;
        bit on;
        on = (!en_n && code == DEV);
        pages = (n == 0) ? 0 : ((int'(a[7:0]) + n - 1) / 256) + 1;
        for (int i = 0; i < n; i++) exp_q.push_back(on ? romw(a + 22'(i)) : 16'hFFFF);
        exp_ptr = a; cur_code = code; cur_en_n = en_n;
        h0 = hi_falls; s0 = strobes;
        @(negedge clk);
        start = 1; word_addr = a; word_count = 16'(n); dev_code = code; enable_n = en_n;
        @(negedge clk);
        start = 0;
        if (disturb) begin
            repeat (40) @(negedge clk);
            start = 1; word_addr = 22'h000777; word_count = 16'd9;
            @(negedge clk);
            start = 0;
        end
        waited = 0;
        while (!done) begin @(negedge clk); waited++; end
        if (n == 0) check(waited == 0, "R10 immediate done", waited, 0);
        check(strobes - s0 == n, "R7 one strobe per word", strobes - s0, n);
        check(exp_q.size() == 0, "R7 word count", exp_q.size(), 0);
        check(hi_falls - h0 == pages, "R8 address cycles", hi_falls - h0, pages);
        check(addr_stb_hi && addr_stb_lo && read_stb_n && !bus_oe, "R9 quiet at done",
              {addr_stb_hi, addr_stb_lo, read_stb_n, bus_oe}, 4'b1110);
        @(negedge clk);
        check(!done, "R9 done single cycle", done, 0);
        if (disturb) begin
            repeat (20) @(negedge clk);
            check(hi_falls - h0 == pages && read_stb_n, "R11 late start ignored", hi_falls - h0, pages);
        end
        exp_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        exp_ptr = '0; cur_code = '0; cur_en_n = 1;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: idle state after reset
        check(addr_stb_hi && addr_stb_lo && read_stb_n, "R1 strobes high",
              {addr_stb_hi, addr_stb_lo, read_stb_n}, 3'b111);
        check(!bus_oe && !done && !rd_valid && rom_sel_n, "R1 outputs idle",
              {bus_oe, done, rd_valid, rom_sel_n}, 4'b0001);
        run_xfer(22'h2A1230, 4, DEV, 1'b0, 1'b1);   // R7, R11
        run_xfer(22'h0000FE, 5, DEV, 1'b0, 1'b0);   // R8 page crossing
        run_xfer(22'h3FFFFE, 3, DEV, 1'b0, 1'b0);   // R8 22-bit wrap
        run_xfer(22'h000010, 3, 4'h5, 1'b0, 1'b0);  // R2 code mismatch, no response
        run_xfer(22'h000020, 2, DEV, 1'b1, 1'b0);   // R2 disabled, no response
        run_xfer(22'h001000, 0, DEV, 1'b0, 1'b0);   // R10 zero count
        run_xfer(22'h1500F0, 40, DEV, 1'b0, 1'b0);  // R6, R7 long burst
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule